// File: doc/BRIEF.md
# Pin Interrupt Detector with Edge, Level and Debounce Modes

The block watches eight already-synchronized input pins and turns chosen transitions or levels on them into interrupt events. Software configures each pin through one 32-bit control word made of four byte-wide fields: a rise enable, a fall enable, a debounce enable and a level-mode select. Each byte holds one bit per pin. The word is never written directly. A write to the set address ORs the data into the word, and a write to the clear address removes the bits that are one in the data.

Detected events are collected in a sticky status register. Software reads that register and clears individual bits by writing ones to a dedicated clear address. A single interrupt line is raised whenever any status bit is set. In level mode the two enable bits take on new meanings: the rise bit selects an active-high trigger and the fall bit selects an active-low trigger. An optional per-pin debounce filter accepts a new pin level only after the level has held for four consecutive sample ticks.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, the control word, the status register, `irq_o` and `rd_data_o` are all zero.
- R2: A write to 0x18 ORs `wr_data_i` into the control word. A write to 0x1C clears the control bits that are one in `wr_data_i`. A read of either address returns the control word. Writes to any other address leave the control word unchanged.
- R3: With a pin's level-mode bit (bit 24+n) clear and its rise bit (bit n) set, a 0-to-1 change on `pin_i[n]` sets status bit n. Without debounce, `irq_o` rises on the second clock edge after the first edge that samples the new level.
- R4: With the level-mode bit clear and the fall bit (bit 8+n) set, a 1-to-0 change on `pin_i[n]` sets status bit n. With both the rise and fall bits set, either change sets it.
- R5: With the level-mode bit set, the rise bit sets status bit n on every cycle that `pin_i[n]` is 1, and the fall bit sets it on every cycle that the pin is 0.
- R6: A pin whose rise and fall bits are both clear never sets its status bit, in any mode and on any input pattern.
- R7: Status bits are sticky. A write to 0x20 clears each status bit that is one in `wr_data_i[7:0]` and leaves the other bits unchanged.
- R8: An event on the same cycle as a status clear for that pin wins, so the bit stays set. A level-mode pin whose level is still active therefore stays set after a clear.
- R9: With the debounce bit (bit 16+n) set, a new level on `pin_i[n]` is accepted only after it has been seen on 4 consecutive cycles with `tick_i` high. A shorter excursion, or any time with `tick_i` low, produces no event.
- R10: `irq_o` is high exactly when at least one status bit is set.
- R11: A read of 0x24 returns the status in bits 7:0 and zeros in bits 31:8. A read of any address other than 0x18, 0x1C and 0x24 returns zero. `rd_data_o` is updated on the clock edge that samples `rd_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Synchronized pin levels |
| tick_i | input | 1 | Debounce sample enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Read byte address |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
The status register has two writers that can act on the same clock edge: a pin event that sets a bit, and a software clear that removes it. The bench provokes this in two ways. First, it changes a both-edge pin one cycle before it issues a clear, so that the falling event and the clear meet on the same edge. Second, it clears a level-mode pin while that pin's level is still active. In both cases the bit must read back as set, and a later clear, issued once the pin is quiet, must actually drop it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned IRQ_PINS = 8;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 8;

  localparam logic [ADDR_W-1:0] ADR_CTRL_SET = 8'h18;
  localparam logic [ADDR_W-1:0] ADR_CTRL_CLR = 8'h1C;
  localparam logic [ADDR_W-1:0] ADR_STAT_CLR = 8'h20;
  localparam logic [ADDR_W-1:0] ADR_STAT_RD  = 8'h24;

  // Field order is fixed by the bit positions software relies on.
  typedef struct packed {
    logic [IRQ_PINS-1:0] lvl;
    logic [IRQ_PINS-1:0] deb;
    logic [IRQ_PINS-1:0] fall;
    logic [IRQ_PINS-1:0] rise;
  } irq_ctrl_t;

  // Set/clear alias update of a register word.
  function automatic logic [DATA_W-1:0] word_update(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] data,
    input logic              do_set,
    input logic              do_clr
  );
    logic [DATA_W-1:0] nxt;
    nxt = cur;
    if (do_set) nxt = nxt | data;
    if (do_clr) nxt = nxt & ~data;
    return nxt;
  endfunction

  // Trigger decision for one pin from its enables and two samples.
  function automatic logic pin_trigger(
    input logic rise_en,
    input logic fall_en,
    input logic lvl_en,
    input logic now,
    input logic prev
  );
    logic hit;
    if (lvl_en) hit = (rise_en & now) | (fall_en & ~now);
    else        hit = (rise_en & now & ~prev) | (fall_en & ~now & prev);
    return hit;
  endfunction

endpackage

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce #(
  parameter int unsigned HOLD_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic tick_i,
  input  logic deb_en_i,
  output logic level_o
);
  localparam int unsigned CNT_W = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_TICKS - 1);

  logic             level_q;
  logic [CNT_W-1:0] cnt_q;
  logic             differs;
  logic             accept;

  assign differs = raw_i ^ level_q;
  assign accept  = tick_i & differs & (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!deb_en_i) begin
      level_q <= raw_i;
      cnt_q   <= '0;
    end else if (tick_i) begin
      if (!differs) begin
        cnt_q <= '0;
      end else if (accept) begin
        level_q <= raw_i;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;

  // R9: with the filter on, the accepted level moves only on a tick
  a_r9_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deb_en_i && !tick_i) |=> $stable(level_o));

  // R9: with the filter on, a change always follows a differing input on a tick
  a_r9_change_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deb_en_i && !differs) |=> $stable(level_o));

endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge
  import gpio_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  input  logic lvl_en_i,
  output logic event_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  assign event_o = pin_trigger(rise_en_i, fall_en_i, lvl_en_i, level_i, prev_q);

  // R3 R4: in edge mode nothing fires while the level holds still
  a_r4_edge_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_en_i && event_o) |-> (level_i != prev_q));

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic [IRQ_PINS-1:0] pin_event_i,
  output irq_ctrl_t           ctrl_o,
  output logic [IRQ_PINS-1:0] status_o,
  output logic [DATA_W-1:0]   rd_data_o
);
  localparam int unsigned PAD_W = DATA_W - IRQ_PINS;

  logic [DATA_W-1:0]   ctrl_q;
  logic [IRQ_PINS-1:0] status_q;
  logic [DATA_W-1:0]   rd_q;
  logic                ctrl_set_stb;
  logic                ctrl_clr_stb;
  logic [IRQ_PINS-1:0] stat_clr_mask;
  logic [DATA_W-1:0]   rd_mux;
  irq_ctrl_t           ctrl_view;

  assign ctrl_set_stb  = wr_en_i && (wr_addr_i == ADR_CTRL_SET);
  assign ctrl_clr_stb  = wr_en_i && (wr_addr_i == ADR_CTRL_CLR);
  assign stat_clr_mask = (wr_en_i && (wr_addr_i == ADR_STAT_CLR)) ?
                         wr_data_i[IRQ_PINS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= word_update(ctrl_q, wr_data_i, ctrl_set_stb, ctrl_clr_stb);
  end

  // New events are ORed after the clear so they win on a shared edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~stat_clr_mask) | pin_event_i;
  end

  always_comb begin
    unique case (rd_addr_i)
      ADR_STAT_RD:               rd_mux = {{PAD_W{1'b0}}, status_q};
      ADR_CTRL_SET, ADR_CTRL_CLR: rd_mux = ctrl_q;
      default:                   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign ctrl_view = irq_ctrl_t'(ctrl_q);
  assign ctrl_o    = ctrl_view;
  assign status_o  = status_q;
  assign rd_data_o = rd_q;

  // R2: a set write leaves every written one present in the word
  a_r2_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_set_stb |=> ((ctrl_q & $past(wr_data_i)) == $past(wr_data_i)));

  // R2: a clear write removes every written one
  a_r2_clr_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_clr_stb && !ctrl_set_stb) |=> ((ctrl_q & $past(wr_data_i)) == '0));

  // R7: a cleared bit without a competing event reads zero next cycle
  a_r7_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_mask != '0) |=> ((status_q & $past(stat_clr_mask & ~pin_event_i)) == '0));

  // R8: an event always lands in the status, even against a clear
  a_r8_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_event_i != '0) |=> ((status_q & $past(pin_event_i)) == $past(pin_event_i)));

  // R6: a masked pin whose bit is clear stays clear
  a_r6_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(~(ctrl_view.rise | ctrl_view.fall) & ~status_q)) == '0));

  // R11: the status read never carries anything above the pin field
  a_r11_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (rd_addr_i == ADR_STAT_RD)) |=> (rd_data_o[DATA_W-1:IRQ_PINS] == '0));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned DEB_HOLD = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IRQ_PINS-1:0] pin_i,
  input  logic                tick_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                irq_o
);
  irq_ctrl_t           ctrl;
  logic [IRQ_PINS-1:0] status;
  logic [IRQ_PINS-1:0] filt_level;
  logic [IRQ_PINS-1:0] pin_event;

  gpio_irq_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .pin_event_i (pin_event),
    .ctrl_o      (ctrl),
    .status_o    (status),
    .rd_data_o   (rd_data_o)
  );

  for (genvar p = 0; p < IRQ_PINS; p++) begin : g_pin
    gpio_irq_debounce #(.HOLD_TICKS(DEB_HOLD)) u_deb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .raw_i    (pin_i[p]),
      .tick_i   (tick_i),
      .deb_en_i (ctrl.deb[p]),
      .level_o  (filt_level[p])
    );

    gpio_irq_edge u_edge (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .level_i   (filt_level[p]),
      .rise_en_i (ctrl.rise[p]),
      .fall_en_i (ctrl.fall[p]),
      .lvl_en_i  (ctrl.lvl[p]),
      .event_o   (pin_event[p])
    );
  end

  assign irq_o = |status;

  // R10: the line can only come up because some pin fired the cycle before
  a_r10_rise_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|pin_event));

  // R6: a masked pin never produces an event
  a_r6_no_masked_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_event & ~(ctrl.rise | ctrl.fall)) == '0));

endmodule

// File: tb/gpio_irq_detect_tb.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin = '0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_detect u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    step(1);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  // modes: 0 rise, 1 fall, 2 both, 3 high level, 4 low level, 5 masked
  function automatic logic [31:0] mode_word(input int m, input int p);
    logic [31:0] r = 32'd1 << p;
    logic [31:0] f = 32'd1 << (8 + p);
    logic [31:0] l = 32'd1 << (24 + p);
    case (m)
      0: return r;
      1: return f;
      2: return r | f;
      3: return r | l;
      4: return f | l;
      default: return l;
    endcase
  endfunction

  function automatic bit exp_hit(input int m, input int ph);
    case (ph)
      0: return m == 4;
      1: return (m == 0) || (m == 2) || (m == 3) || (m == 4);
      2: return m == 3;
      3: return (m == 1) || (m == 2) || (m == 3) || (m == 4);
      default: return m == 4;
    endcase
  endfunction

  task automatic quiesce();
    pin = '0; tick = 1'b0;
    step(3);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFF);
    step(1);
  endtask

  task automatic sweep_read(input int m, input int p, input int ph);
    logic [31:0] d;
    logic [31:0] e;
    e = exp_hit(m, ph) ? (32'd1 << p) : 32'd0;
    rd(8'h24, d);
    check($sformatf("R3 R4 R5 R6 mode%0d pin%0d phase%0d", m, p, ph), d, e);
    check($sformatf("R10 irq mode%0d pin%0d phase%0d", m, p, ph), {31'd0, irq}, {31'd0, e != 0});
  endtask

  initial begin
    logic [31:0] d;
    step(3);
    // R1: state straight out of reset
    rst_n = 1'b1;
    step(1);
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    check("R1 rd_data after reset", rd_data, 32'd0);
    rd(8'h18, d); check("R1 control word after reset", d, 32'd0);
    rd(8'h24, d); check("R1 status after reset", d, 32'd0);

    // R2: set/clear aliases and ignored addresses
    wr(8'h18, 32'h1234_5678);
    rd(8'h18, d); check("R2 set alias", d, 32'h1234_5678);
    wr(8'h1C, 32'h00FF_00FF);
    rd(8'h1C, d); check("R2 clear alias", d, 32'h1200_5600);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h18, d); check("R2 other writes ignored", d, 32'h1200_5600);
    rd(8'h30, d); check("R11 unmapped read is zero", d, 32'd0);
    quiesce();

    // R3..R6, R10: every mode on every pin through a full rise/fall cycle
    for (int m = 0; m < 6; m++) begin
      for (int p = 0; p < 8; p++) begin
        quiesce();
        wr(8'h18, mode_word(m, p));
        step(3);
        sweep_read(m, p, 0);
        pin[p] = 1'b1; step(3);
        sweep_read(m, p, 1);
        wr(8'h20, 32'hFF); step(1);
        sweep_read(m, p, 2);
        pin[p] = 1'b0; step(3);
        sweep_read(m, p, 3);
        wr(8'h20, 32'hFF); step(1);
        sweep_read(m, p, 4);
      end
    end

    // R3: exact latency without debounce
    quiesce();
    wr(8'h18, 32'h0000_0001);
    step(2);
    pin[0] = 1'b1;
    step(1); check("R3 irq not yet after first edge", {31'd0, irq}, 32'd0);
    step(1); check("R3 irq on second edge", {31'd0, irq}, 32'd1);

    // R11: all pins firing, upper bits stay zero
    quiesce();
    wr(8'h18, 32'h0000_00FF);
    step(2);
    pin = 8'hFF; step(3);
    rd(8'h24, d); check("R11 all pins status", d, 32'h0000_00FF);

    // R7: selective clear
    wr(8'h20, 32'h0000_00A5); step(1);
    rd(8'h24, d); check("R7 partial clear", d, 32'h0000_005A);

    // R8: falling event and clear on the same edge
    quiesce();
    wr(8'h18, mode_word(2, 1));
    step(2);
    pin[1] = 1'b1; step(3);
    rd(8'h24, d); check("R8 both-edge rise captured", d, 32'h2);
    pin[1] = 1'b0; step(1);
    wr(8'h20, 32'h2);
    rd(8'h24, d); check("R8 event beats clear", d, 32'h2);
    wr(8'h20, 32'h2); step(1);
    rd(8'h24, d); check("R8 quiet clear drops bit", d, 32'h0);

    // R8: active level survives clear, then drops once inactive
    quiesce();
    wr(8'h18, mode_word(3, 6));
    pin[6] = 1'b1; step(3);
    wr(8'h20, 32'hFF); step(1);
    rd(8'h24, d); check("R8 active level stays after clear", d, 32'h40);
    pin[6] = 1'b0; step(2);
    wr(8'h20, 32'hFF); step(1);
    rd(8'h24, d); check("R8 inactive level clears", d, 32'h0);

    // R9: debounce on pin 2, rising edge
    quiesce();
    wr(8'h18, 32'h0004_0004);
    step(2);
    tick = 1'b0;
    pin[2] = 1'b1; step(10);
    check("R9 no ticks, no event", {31'd0, irq}, 32'd0);
    pin[2] = 1'b0; step(2);
    tick = 1'b1;
    pin[2] = 1'b1; step(3);
    pin[2] = 1'b0; step(4);
    check("R9 three-tick glitch ignored", {31'd0, irq}, 32'd0);
    pin[2] = 1'b1; step(4);
    check("R9 not before fourth tick lands", {31'd0, irq}, 32'd0);
    step(1);
    check("R9 accepted after four ticks", {31'd0, irq}, 32'd1);
    rd(8'h24, d); check("R9 debounced status", d, 32'h4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule